// File: doc/BRIEF.md
# Four-Channel PS/2 Host Controller with Shared Shifter

This block is the host side of four PS/2 ports that share a single frame shifter. Each port has an open-drain clock line and an open-drain data line. Software holds a port's clock low to inhibit it and lets go of the clock to make the port eligible. The first eligible port whose clock falls takes the shifter for one whole 11-bit frame. In receive mode the shifter collects the device's byte and checks the start bit, the odd parity bit and the stop bit. In transmit mode it answers a request-to-send by shifting out the stored byte.

Software drives the block through plain register-field inputs: an enable bit, a transmit-mode bit, a weak pull-up bit, an 8-bit line-release word and two interrupt enables. It reads back a status set and a data byte. The start and end flags are sticky. Only a shifter reset clears them, and software causes that reset by holding every clock-release bit at 0 or by clearing the enable bit. A 3-bit owner code tells software which port holds the shifter.

Top module: `ps2sh_top`

## Requirements
- R1: While every clock-release bit is 0 or the enable is 0, the shifter is reset: start flag, end flag, parity error and frame error read 0 and the owner code reads 0. The data byte is kept.
- R2: Clock-release bits sit at `osig` bit 3 (port 0), bit 4 (port 1), bit 5 (port 2) and bit 7 (port 3). Data-release bits sit at bit 0, 1, 2 and 6 for ports 0 to 3. A bit at 0 asserts that port's output-enable, which pulls the line low. The one exception is the data line of a port the shifter is transmitting on.
- R3: A received frame is start, eight data bits LSB first, parity, stop. At the 11th falling clock edge the data byte output takes the eight data bits.
- R4: The start flag sets at the falling clock edge that hands a port the shifter and stays set until a shifter reset. The end flag sets at that port's 11th falling edge and also stays set.
- R5: In receive mode the parity-error flag sets at frame end when the data bits plus the parity bit hold an even number of ones.
- R6: In receive mode the frame-error flag sets at frame end when the start bit is 1 or the stop bit is 0.
- R7: While a port holds the shifter, the owner code reads 1 for port 0, 2 for port 1, 4 for port 2 and 5 for port 3. It reads 0 otherwise.
- R8: Only ports whose clock is released can take the shifter. When clocks fall in the same cycle, the lowest-numbered port wins, and the other ports have no effect on the frame.
- R9: In transmit mode, after falling edges 1 to 8 the shifter presents data bits 0 to 7. After edge 9 it presents odd parity, and after edge 10 it releases the line. At edge 11 it samples the device acknowledge: a high line sets the frame-error flag. The end flag sets in either case.
- R10: `irq` is high when the start flag is set and `ien_sot` is 1, or when the end flag is set and `ien_eot` is 1.
- R11: With the enable at 0, falling clocks are ignored: no flag sets and the data byte is unchanged. `pullup_en` follows `cfg_wpu`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Shifter enable |
| cfg_xmt | input | 1 | 1 = transmit mode, 0 = receive mode |
| cfg_wpu | input | 1 | Weak pull-up request |
| osig | input | 8 | Per-port clock-release and data-release bits |
| ien_sot | input | 1 | Interrupt enable for the start flag |
| ien_eot | input | 1 | Interrupt enable for the end flag |
| dat_wr | input | 1 | Write strobe for the data byte |
| dat_wdata | input | 8 | Byte to be transmitted |
| ps2_clk_i | input | 4 | Sensed clock lines |
| ps2_dat_i | input | 4 | Sensed data lines |
| ps2_clk_oe | output | 4 | Pull clock line low |
| ps2_dat_oe | output | 4 | Pull data line low |
| pullup_en | output | 1 | Weak pull-up enable |
| st_sot | output | 1 | Sticky start flag |
| st_eot | output | 1 | Sticky end flag |
| st_perr | output | 1 | Parity error |
| st_ferr | output | 1 | Frame or acknowledge error |
| st_ach | output | 3 | Owner code |
| dat_q | output | 8 | Data byte (received or to send) |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted bit counter shows up at the ports as an end flag that rises early or late. It also corrupts the received byte, or shifts the bits a device reads out of a transmit, and either is visible by the end of the same frame. A wrong owner register shows up as an illegal or mismatched owner code as soon as the shifter is taken. The flag checks watch the sticky flags and the owner code every cycle, so a leaked flag is caught one cycle after a shifter reset.

// File: rtl/ps2sh_pkg.sv
package ps2sh_pkg;
    localparam int NCH = 4;
    localparam int CW  = $clog2(NCH);
    localparam int FRAME_LAST = 10;

    typedef enum logic [1:0] {ENG_IDLE, ENG_SHIFT, ENG_DONE} eng_state_e;

    typedef struct packed {
        logic sot;
        logic eot;
        logic perr;
        logic ferr;
    } eng_flags_t;

    // release-bit positions in the output-signal word
    function automatic int clk_pos(int c);
        return (c == NCH - 1) ? 7 : 3 + c;
    endfunction

    function automatic int dat_pos(int c);
        return (c == NCH - 1) ? 6 : c;
    endfunction

    // owner code: 0->1, 1->2, 2->4, 3->5
    function automatic logic [2:0] ach_code(logic [CW-1:0] c);
        return (c >= CW'(2)) ? 3'(c) + 3'd2 : 3'(c) + 3'd1;
    endfunction
endpackage

// File: rtl/ps2sh_deglitch.sv
module ps2sh_deglitch #(
    parameter int FILT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int FW = $clog2(FILT + 1);

    logic          s1, s2;
    logic [FW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1  <= 1'b1;
            s2  <= 1'b1;
            q   <= 1'b1;
            cnt <= '0;
        end else begin
            s1 <= d;
            s2 <= s1;
            if (s2 != q) begin
                if (cnt == FW'(FILT - 1)) begin
                    q   <= s2;
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                cnt <= '0;
            end
        end
    end
endmodule

// File: rtl/ps2sh_pick.sv
module ps2sh_pick #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic [N-1:0] req,
    output logic         hit,
    output logic [W-1:0] idx
);
    always_comb begin
        hit = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/ps2sh_engine.sv
module ps2sh_engine
    import ps2sh_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           mrst,
    input  logic           xmt,
    input  logic [NCH-1:0] clk_f,
    input  logic [NCH-1:0] dat_f,
    input  logic [NCH-1:0] rel,
    input  logic           dat_wr,
    input  logic [7:0]     wdata,
    output eng_flags_t     flags,
    output logic [CW-1:0]  own,
    output logic           busy,
    output logic           tx_drive,
    output logic           tx_bit,
    output logic [7:0]     dq
);
    eng_state_e     st;
    logic [NCH-1:0] clk_d, fall;
    logic [3:0]     bcnt;
    logic [9:0]     frm;
    logic           tx_mode;
    logic           hit;
    logic [CW-1:0]  win;
    logic           own_fall, own_dat;

    assign fall     = clk_d & ~clk_f & rel;
    assign own_fall = fall[own];
    assign own_dat  = dat_f[own];
    assign busy     = (st != ENG_IDLE);
    assign tx_drive = tx_mode && (st == ENG_SHIFT);

    ps2sh_pick #(.N(NCH), .W(CW)) u_pick (.req(fall), .hit(hit), .idx(win));

    always_ff @(posedge clk) begin
        if (rst) clk_d <= '1;
        else     clk_d <= clk_f;
    end

    always_ff @(posedge clk) begin
        if (rst)
            dq <= '0;
        else if (st == ENG_SHIFT && !tx_mode && own_fall && bcnt == 4'(FRAME_LAST))
            dq <= frm[8:1];
        else if (dat_wr)
            dq <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || mrst) begin
            st      <= ENG_IDLE;
            flags   <= '0;
            own     <= '0;
            bcnt    <= '0;
            frm     <= '0;
            tx_mode <= 1'b0;
            tx_bit  <= 1'b1;
        end else begin
            case (st)
                ENG_IDLE: if (hit) begin
                    own       <= win;
                    st        <= ENG_SHIFT;
                    flags.sot <= 1'b1;
                    bcnt      <= 4'd1;
                    tx_mode   <= xmt;
                    frm[0]    <= dat_f[win];
                    tx_bit    <= dq[0];
                end
                ENG_SHIFT: if (own_fall) begin
                    bcnt <= bcnt + 4'd1;
                    if (tx_mode) begin
                        if (bcnt < 4'd8)       tx_bit <= dq[bcnt[2:0]];
                        else if (bcnt == 4'd8) tx_bit <= ~^dq;
                        else if (bcnt == 4'd9) tx_bit <= 1'b1;
                        else begin
                            flags.ferr <= own_dat;
                            flags.eot  <= 1'b1;
                            st         <= ENG_DONE;
                        end
                    end else begin
                        if (bcnt < 4'(FRAME_LAST)) begin
                            frm[bcnt] <= own_dat;
                        end else begin
                            flags.eot  <= 1'b1;
                            flags.perr <= ~(^frm[9:1]);
                            flags.ferr <= frm[0] | ~own_dat;
                            st         <= ENG_DONE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ps2sh_top.sv
module ps2sh_top
    import ps2sh_pkg::*;
#(
    parameter int FILT = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_en,
    input  logic           cfg_xmt,
    input  logic           cfg_wpu,
    input  logic [7:0]     osig,
    input  logic           ien_sot,
    input  logic           ien_eot,
    input  logic           dat_wr,
    input  logic [7:0]     dat_wdata,
    input  logic [NCH-1:0] ps2_clk_i,
    input  logic [NCH-1:0] ps2_dat_i,
    output logic [NCH-1:0] ps2_clk_oe,
    output logic [NCH-1:0] ps2_dat_oe,
    output logic           pullup_en,
    output logic           st_sot,
    output logic           st_eot,
    output logic           st_perr,
    output logic           st_ferr,
    output logic [2:0]     st_ach,
    output logic [7:0]     dat_q,
    output logic           irq
);
    logic [NCH-1:0] rel, clk_f, dat_f;
    logic           mrst, busy, tx_drive, tx_bit;
    logic [CW-1:0]  own;
    eng_flags_t     flags;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int CP = clk_pos(c);
        localparam int DP = dat_pos(c);
        assign rel[c]        = osig[CP];
        assign ps2_clk_oe[c] = ~osig[CP];
        assign ps2_dat_oe[c] = (tx_drive && own == CW'(c)) ? ~tx_bit : ~osig[DP];
        ps2sh_deglitch #(.FILT(FILT)) u_fc (.clk(clk), .rst(rst), .d(ps2_clk_i[c]), .q(clk_f[c]));
        ps2sh_deglitch #(.FILT(FILT)) u_fd (.clk(clk), .rst(rst), .d(ps2_dat_i[c]), .q(dat_f[c]));
    end

    assign mrst = !cfg_en || (rel == '0);

    ps2sh_engine u_eng (
        .clk(clk), .rst(rst), .mrst(mrst), .xmt(cfg_xmt),
        .clk_f(clk_f), .dat_f(dat_f), .rel(rel),
        .dat_wr(dat_wr), .wdata(dat_wdata),
        .flags(flags), .own(own), .busy(busy),
        .tx_drive(tx_drive), .tx_bit(tx_bit), .dq(dat_q)
    );

    assign st_sot    = flags.sot;
    assign st_eot    = flags.eot;
    assign st_perr   = flags.perr;
    assign st_ferr   = flags.ferr;
    assign st_ach    = busy ? ach_code(own) : 3'd0;
    assign irq       = (flags.sot & ien_sot) | (flags.eot & ien_eot);
    assign pullup_en = cfg_wpu;
endmodule

// File: rtl/ps2sh_chk.sv
module ps2sh_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_en,
    input logic [3:0] clk_rel,
    input logic       st_sot,
    input logic       st_eot,
    input logic [2:0] st_ach
);
    // R1: a shifter reset clears flags and owner on the next cycle
    a_r1_mech_clear: assert property (@(posedge clk) disable iff (rst)
        (clk_rel == 4'd0 || !cfg_en) |=> (!st_sot && !st_eot && st_ach == 3'd0));

    // R4: start flag is sticky while no shifter reset is requested
    a_r4_sot_sticky: assert property (@(posedge clk) disable iff (rst)
        (st_sot && clk_rel != 4'd0 && cfg_en) |=> st_sot);

    // R4: end flag only ever appears after the start flag
    a_r4_eot_after_sot: assert property (@(posedge clk) disable iff (rst)
        $rose(st_eot) |-> $past(st_sot));

    // R7: owner code is one of the four legal values or zero
    a_r7_ach_legal: assert property (@(posedge clk) disable iff (rst)
        (st_ach == 3'd0 || st_ach == 3'd1 || st_ach == 3'd2 || st_ach == 3'd4 || st_ach == 3'd5));

    // R7: a nonzero owner code goes with a set start flag
    a_r7_ach_with_sot: assert property (@(posedge clk) disable iff (rst)
        ((st_ach != 3'd0) == st_sot));
endmodule

bind ps2sh_top ps2sh_chk u_chk (
    .clk(clk), .rst(rst), .cfg_en(cfg_en),
    .clk_rel({osig[7], osig[5:3]}),
    .st_sot(st_sot), .st_eot(st_eot), .st_ach(st_ach)
);

// File: tb/sim_ps2sh_top.sv
module sim_ps2sh_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic       cfg_en = 1'b1, cfg_xmt = 1'b0, cfg_wpu = 1'b1;
    logic [7:0] osig = 8'h47;
    logic       ien_sot = 1'b1, ien_eot = 1'b1;
    logic       dat_wr = 1'b0;
    logic [7:0] dat_wdata = 8'h00;
    logic [3:0] dev_clk = 4'hF, dev_dat = 4'hF;
    logic [3:0] line_clk, line_dat, ps2_clk_oe, ps2_dat_oe;
    logic       pullup_en, st_sot, st_eot, st_perr, st_ferr, irq;
    logic [2:0] st_ach;
    logic [7:0] dat_q;

    assign line_clk = dev_clk & ~ps2_clk_oe;
    assign line_dat = dev_dat & ~ps2_dat_oe;

    ps2sh_top u0 (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_xmt(cfg_xmt), .cfg_wpu(cfg_wpu),
        .osig(osig), .ien_sot(ien_sot), .ien_eot(ien_eot),
        .dat_wr(dat_wr), .dat_wdata(dat_wdata),
        .ps2_clk_i(line_clk), .ps2_dat_i(line_dat),
        .ps2_clk_oe(ps2_clk_oe), .ps2_dat_oe(ps2_dat_oe), .pullup_en(pullup_en),
        .st_sot(st_sot), .st_eot(st_eot), .st_perr(st_perr), .st_ferr(st_ferr),
        .st_ach(st_ach), .dat_q(dat_q), .irq(irq)
    );

    localparam int H = 16;
    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    // {port[1:0], byte[7:0], bad_parity, bad_start, bad_stop}
    localparam logic [12:0] VEC [8] = '{
        {2'd0, 8'h5A, 1'b0, 1'b0, 1'b0},
        {2'd1, 8'h00, 1'b0, 1'b0, 1'b0},
        {2'd2, 8'hFF, 1'b0, 1'b0, 1'b0},
        {2'd3, 8'h81, 1'b0, 1'b0, 1'b0},
        {2'd0, 8'h37, 1'b1, 1'b0, 1'b0},
        {2'd2, 8'hC4, 1'b0, 1'b1, 1'b0},
        {2'd3, 8'h19, 1'b0, 1'b0, 1'b1},
        {2'd1, 8'hE2, 1'b1, 1'b0, 1'b1}
    };

    function automatic logic [2:0] exp_code(int p);
        case (p)
            0: return 3'd1;
            1: return 3'd2;
            2: return 3'd4;
            default: return 3'd5;
        endcase
    endfunction

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic mreset();
        osig = 8'h47;
        cyc(2 * H);
    endtask

    task automatic dev_send(logic [3:0] m, logic [7:0] b, bit bpar, bit bstart, bit bstop, int nb);
        logic [10:0] f;
        f = {~bstop, (~^b) ^ bpar, b, bstart};
        for (int i = 0; i < nb; i++) begin
            dev_dat = f[i] ? (dev_dat | m) : (dev_dat & ~m);
            cyc(H);
            dev_clk = dev_clk & ~m;
            cyc(H);
            dev_clk = dev_clk | m;
        end
        dev_dat = dev_dat | m;
        cyc(2 * H);
    endtask

    task automatic dev_recv(int p, bit ack, output logic [10:0] got);
        got = '0;
        for (int k = 1; k <= 10; k++) begin
            dev_clk[p] = 1'b0;
            cyc(H);
            dev_clk[p] = 1'b1;
            cyc(H / 2);
            got[k] = line_dat[p];
            cyc(H / 2);
        end
        if (ack) dev_dat[p] = 1'b0;
        cyc(H);
        dev_clk[p] = 1'b0;
        cyc(H);
        dev_clk[p] = 1'b1;
        cyc(H / 2);
        dev_dat[p] = 1'b1;
        cyc(2 * H);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [10:0] got;
        cyc(5);
        rst = 1'b0;
        cyc(2 * H);
        // reset state
        chk("R1 sot after reset", st_sot, 0);
        chk("R1 eot after reset", st_eot, 0);
        chk("R1 ach after reset", st_ach, 0);
        chk("R10 irq after reset", irq, 0);
        chk("R2 all clocks inhibited", ps2_clk_oe, 4'hF);
        chk("R2 data lines released", ps2_dat_oe, 4'h0);
        chk("R11 pull-up follows", pullup_en, 1);
        cfg_wpu = 1'b0;
        cyc(1);
        chk("R11 pull-up off", pullup_en, 0);

        // receive vectors
        foreach (VEC[v]) begin
            int p;
            logic [7:0] b;
            p = int'(VEC[v][12:11]);
            b = VEC[v][10:3];
            mreset();
            osig = 8'hFF;
            cyc(2 * H);
            dev_send(4'(1 << p), b, VEC[v][2], VEC[v][1], VEC[v][0], 11);
            chk("R4 sot after frame", st_sot, 1);
            chk("R4 eot after frame", st_eot, 1);
            chk("R7 owner code", st_ach, exp_code(p));
            chk("R5 parity error", st_perr, VEC[v][2]);
            chk("R6 frame error", st_ferr, VEC[v][1] | VEC[v][0]);
            chk("R3 received byte", dat_q, b);
            chk("R10 irq at end", irq, 1);
        end

        // R2 individual release bits
        mreset();
        osig = 8'hFF & ~8'h40;
        cyc(2);
        chk("R2 port3 data pulled", ps2_dat_oe, 4'b1000);
        osig = 8'hFF & ~8'h20;
        cyc(2);
        chk("R2 port2 clock pulled", ps2_clk_oe, 4'b0100);

        // partial frame: sticky start, no end, irq from start only, then reset
        mreset();
        ien_sot = 1'b1;
        ien_eot = 1'b0;
        osig = 8'hFF;
        cyc(2 * H);
        dev_send(4'b0010, 8'h4D, 0, 0, 0, 3);
        chk("R4 sot mid frame", st_sot, 1);
        chk("R4 eot mid frame", st_eot, 0);
        chk("R7 owner mid frame", st_ach, 3'd2);
        chk("R10 irq from start enable", irq, 1);
        osig = 8'h47;
        cyc(4);
        chk("R1 sot cleared by shifter reset", st_sot, 0);
        chk("R1 owner cleared by shifter reset", st_ach, 0);
        ien_sot = 1'b0;
        ien_eot = 1'b1;

        // R8 simultaneous falls: lowest port wins
        mreset();
        osig = 8'hFF;
        cyc(2 * H);
        dev_send(4'b1010, 8'h3C, 0, 0, 0, 11);
        chk("R8 lowest simultaneous port wins", st_ach, 3'd2);
        chk("R8 winner byte", dat_q, 8'h3C);
        chk("R10 irq from end enable only", irq, 1);

        // R8 inhibited port cannot take the shifter
        mreset();
        osig = 8'hC7;
        cyc(2 * H);
        dev_send(4'b0001, 8'h11, 0, 0, 0, 11);
        chk("R8 inhibited port ignored", st_sot, 0);
        dev_send(4'b1000, 8'h6B, 0, 0, 0, 11);
        chk("R8 released port takes shifter", st_ach, 3'd5);
        chk("R8 released port byte", dat_q, 8'h6B);

        // R11 disabled shifter ignores clocks
        mreset();
        cfg_en = 1'b0;
        osig = 8'hFF;
        cyc(2 * H);
        dev_send(4'b0001, 8'h99, 0, 0, 0, 11);
        chk("R11 disabled no start", st_sot, 0);
        chk("R11 disabled byte kept", dat_q, 8'h6B);
        cfg_en = 1'b1;

        // R9 transmit with acknowledge on port 2
        mreset();
        cfg_xmt = 1'b1;
        dat_wdata = 8'hA5;
        dat_wr = 1'b1;
        cyc(1);
        dat_wr = 1'b0;
        chk("R9 byte written", dat_q, 8'hA5);
        osig = 8'h63;
        cyc(H);
        chk("R9 request-to-send data low", ps2_dat_oe[2], 1);
        dev_recv(2, 1'b1, got);
        chk("R9 transmitted byte", got[8:1], 8'hA5);
        chk("R9 odd parity bit", got[9], ~^8'hA5);
        chk("R9 stop released", got[10], 1);
        chk("R9 end after ack", st_eot, 1);
        chk("R9 no error with ack", st_ferr, 0);
        chk("R7 transmit owner", st_ach, 3'd4);

        // R9 missing acknowledge
        mreset();
        osig = 8'h63;
        cyc(H);
        dev_recv(2, 1'b0, got);
        chk("R9 end without ack", st_eot, 1);
        chk("R9 error without ack", st_ferr, 1);
        cfg_xmt = 1'b0;

        finish_run();
    end
endmodule